// File: doc/BRIEF.md
# I2C master SCL clock generator

This block derives the serial clock line for a master I2C engine from a single system clock. A 5-bit divider code and a fast-mode bit set the clock period: in standard timing one SCL period lasts eight system clocks per unit of code, and in fast timing four. Both halves of the period are equal except for one setting, fast timing with code 5, where the low phase is 12 clocks and the high phase 8 (a 3:2 ratio). Codes too small for the chosen timing are refused: the line stays released and an error flag is raised.

The byte engine drives a run request to start and stop the clock, and a hold request to stretch the low phase while it prepares data. The generator answers with one-cycle strobes on every SCL rising and falling edge, so the engine can sample SDA on the rise and change it on the fall. A pulse on the configuration-write input, issued whenever the control register is written, aborts any clock in progress and returns the generator to idle.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, scl is 1 and both scl_rise and scl_fall are 0.
- R2: With fast_mode=0 and a legal code N, the low phase and the high phase each last 4*N system clocks (period 8*N).
- R3: With fast_mode=1 and a legal code N other than 5, the low phase and the high phase each last 2*N system clocks (period 4*N).
- R4: With fast_mode=1 and code 5, the low phase lasts 12 system clocks and the high phase 8.
- R5: Codes 0, 1 and 2 are forbidden in both timings, and codes 3 and 4 are also forbidden when fast_mode=0; with a forbidden code config_error is 1, scl stays 1 and no strobe is produced. Codes 5 (standard) and 3 (fast) are legal and config_error is 0 for them.
- R6: From idle, with run=1 and a legal code, the clock begins with a falling edge on the clock cycle after run is seen, so every period starts with its low phase.
- R7: When run is dropped, the phase in progress completes, the following high phase completes, and scl then stays 1 with no further falling edge.
- R8: While hold is 1 during a low phase, scl stays 0; the rising edge comes exactly one full low-phase time after hold returns to 0. Hold asserted and released within a high phase has no effect on that phase's length.
- R9: scl_rise is 1 for one cycle exactly when scl changes from 0 to 1, and scl_fall for one cycle exactly when scl changes from 1 to 0; the two are never 1 together.
- R10: A pulse on cfg_wr returns the generator to idle with scl at 1 on the next cycle (with a scl_rise strobe if scl was 0); if run is still 1, a new period begins with a falling edge on the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_code | input | 5 | Divider code setting the SCL period |
| fast_mode | input | 1 | 1 selects fast timing, 0 standard timing |
| cfg_wr | input | 1 | One-cycle pulse on a control register write; restarts the generator |
| run | input | 1 | Request to generate clock periods |
| hold | input | 1 | Request to stretch the current low phase |
| scl | output | 1 | Generated serial clock, 1 meaning released |
| scl_rise | output | 1 | One-cycle strobe on each SCL rising edge |
| scl_fall | output | 1 | One-cycle strobe on each SCL falling edge |
| config_error | output | 1 | The programmed code is forbidden for the chosen timing |

## Verification
The phase lengths are measured under standard timing at the smallest legal code and at the largest code, and under fast timing at its smallest legal code, a middle code, the largest code and the special 3:2 setting; together these separate the two multipliers from each other, expose an off-by-one in the phase counter, and show that the asymmetric duty is confined to a single setting. Forbidden codes are tried just below each timing's lower limit, which tells the per-timing thresholds apart. Stop, hold in both phases, and a mid-phase configuration write check that phases are only shortened by an explicit restart and that stretching counts from the release of hold.

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int CODE_W         = 5,
  parameter int STD_HALF_MUL   = 4,
  parameter int FAST_HALF_MUL  = 2,
  parameter int STD_MIN_CODE   = 5,
  parameter int FAST_MIN_CODE  = 3,
  parameter int ASYM_CODE      = 5,
  parameter int ASYM_LOW       = 12,
  parameter int ASYM_HIGH      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic              fast_mode,
  input  logic              cfg_wr,
  input  logic              run,
  input  logic              hold,
  output logic              scl,
  output logic              scl_rise,
  output logic              scl_fall,
  output logic              config_error
);
  localparam int CNT_W = $clog2(STD_HALF_MUL * (2 ** CODE_W)) + 1;

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] code_w, half_t, low_t, high_t;
  logic             asym;

  assign code_w = CNT_W'(div_code);
  assign half_t = fast_mode ? code_w * CNT_W'(FAST_HALF_MUL)
                            : code_w * CNT_W'(STD_HALF_MUL);
  assign asym   = fast_mode && (div_code == CODE_W'(ASYM_CODE));
  assign low_t  = asym ? CNT_W'(ASYM_LOW)  : half_t;
  assign high_t = asym ? CNT_W'(ASYM_HIGH) : half_t;

  assign config_error = fast_mode ? (div_code < CODE_W'(FAST_MIN_CODE))
                                  : (div_code < CODE_W'(STD_MIN_CODE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      scl      <= 1'b1;
      cnt      <= '0;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
    end else begin
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      if (cfg_wr || config_error) begin
        active <= 1'b0;
        cnt    <= '0;
        if (!scl) begin
          scl      <= 1'b1;
          scl_rise <= 1'b1;
        end
      end else if (!active) begin
        cnt <= '0;
        if (run) begin
          active   <= 1'b1;
          scl      <= 1'b0;
          scl_fall <= 1'b1;
        end
      end else if (!scl) begin
        if (hold) begin
          cnt <= '0;
        end else if (cnt == low_t - 1'b1) begin
          cnt      <= '0;
          scl      <= 1'b1;
          scl_rise <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == high_t - 1'b1) begin
          cnt <= '0;
          if (run) begin
            scl      <= 1'b0;
            scl_fall <= 1'b1;
          end else begin
            active <= 1'b0;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic hold,
  input logic scl,
  input logic scl_rise,
  input logic scl_fall,
  input logic config_error
);
  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall}));

  assert_rise_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl) |-> scl_rise);

  assert_fall_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl) |-> scl_fall);

  assert_bad_code_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> (scl && !scl_fall));

  assert_hold_keeps_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !scl && !cfg_wr && !config_error) |=> !scl);

  assert_cfg_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (scl && !scl_fall));
endmodule

bind scl_clkgen scl_clkgen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .hold(hold), .scl(scl),
  .scl_rise(scl_rise), .scl_fall(scl_fall), .config_error(config_error)
);

// File: tb/test_scl_clkgen.sv
module test_scl_clkgen;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] div_code = 5'd5;
  logic       fast_mode = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       run = 1'b0;
  logic       hold = 1'b0;
  logic       scl, scl_rise, scl_fall, config_error;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  scl_clkgen i_scl_clkgen (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .fast_mode(fast_mode),
    .cfg_wr(cfg_wr), .run(run), .hold(hold), .scl(scl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .config_error(config_error)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!scl_fall && n < 2000);
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!scl_rise && n < 2000);
  endtask

  task automatic configure(input logic [4:0] code, input logic fm);
    @(negedge clk);
    div_code = code; fast_mode = fm; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic go_idle();
    run = 1'b0; hold = 1'b0;
    repeat (300) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(scl === 1'b1, "R1 scl", scl, 1);
    check(scl_rise === 1'b0 && scl_fall === 1'b0, "R1 strobes", {scl_rise, scl_fall}, 0);
  endtask

  task automatic t_period(input logic [4:0] code, input logic fm,
                          input int lo, input int hi, input string req);
    int n;
    configure(code, fm);
    check(config_error === 1'b0, {req, " legal code"}, config_error, 0);
    run = 1'b1;
    wait_fall(n);
    check(n == 1, "R6 first fall one cycle after run", n, 1);
    check(scl === 1'b0, "R9 scl low with fall strobe", scl, 0);
    wait_rise(n);
    check(n == lo, {req, " low phase"}, n, lo);
    check(scl === 1'b1, "R9 scl high with rise strobe", scl, 1);
    wait_fall(n);
    check(n == hi, {req, " high phase"}, n, hi);
    go_idle();
  endtask

  task automatic t_forbidden(input logic [4:0] code, input logic fm);
    int falls = 0;
    configure(code, fm);
    run = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (scl_fall || scl_rise || !scl) falls++;
    end
    check(config_error === 1'b1, "R5 error flag", config_error, 1);
    check(falls == 0, "R5 no toggling", falls, 0);
    go_idle();
  endtask

  task automatic t_stop();
    int n, falls = 0;
    configure(5'd5, 1'b0);
    run = 1'b1;
    wait_fall(n);
    repeat (3) @(negedge clk);
    run = 1'b0;
    wait_rise(n);
    check(n == 17, "R7 low phase completes", n, 17);
    repeat (100) begin
      @(negedge clk);
      if (scl_fall || !scl) falls++;
    end
    check(falls == 0, "R7 no fall after stop", falls, 0);
  endtask

  task automatic t_hold_low();
    int n, lows = 0;
    configure(5'd5, 1'b0);
    run = 1'b1;
    wait_fall(n);
    repeat (5) @(negedge clk);
    hold = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (scl === 1'b0) lows++;
    end
    check(lows == 30, "R8 scl low while held", lows, 30);
    hold = 1'b0;
    wait_rise(n);
    check(n == 20, "R8 rise one low time after release", n, 20);
    go_idle();
  endtask

  task automatic t_hold_high();
    int n = 0;
    configure(5'd10, 1'b1);
    run = 1'b1;
    wait_fall(n);
    wait_rise(n);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 3) hold = 1'b1;
      if (n == 8) hold = 1'b0;
    end while (!scl_fall && n < 2000);
    check(n == 20, "R8 hold ignored in high phase", n, 20);
    go_idle();
  endtask

  task automatic t_restart();
    int n;
    configure(5'd5, 1'b1);
    run = 1'b1;
    wait_fall(n);
    repeat (4) @(negedge clk);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    check(scl === 1'b1 && scl_rise === 1'b1, "R10 released with rise",
          {scl, scl_rise}, 3);
    @(negedge clk);
    check(scl_fall === 1'b1, "R10 restart fall", scl_fall, 1);
    wait_rise(n);
    check(n == 12, "R10 full low after restart", n, 12);
    go_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period(5'd5,  1'b0, 20,  20,  "R2 std code 5");
    t_period(5'd31, 1'b0, 124, 124, "R2 std code 31");
    t_period(5'd3,  1'b1, 6,   6,   "R3 fast code 3");
    t_period(5'd9,  1'b1, 18,  18,  "R3 fast code 9");
    t_period(5'd31, 1'b1, 62,  62,  "R3 fast code 31");
    t_period(5'd5,  1'b1, 12,  8,   "R4 fast code 5");
    t_forbidden(5'd4, 1'b0);
    t_forbidden(5'd2, 1'b1);
    t_forbidden(5'd0, 1'b0);
    t_stop();
    t_hold_low();
    t_hold_high();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule